// File: doc/BRIEF.md
# Checkpointed Register Rename Table

This block keeps the live mapping from architectural registers to physical register tags for a small out-of-order core. It also keeps a small pool of snapshot slots. A rename request writes one destination mapping per cycle. A branch-allocate request takes a full copy of the live mapping into a free slot and returns that slot's number as the branch's checkpoint identifier. If every slot is busy, the block raises a stall instead.

A branch resolve names a slot. If the branch was predicted correctly, the slot simply goes back to the pool. If it was mispredicted, the saved copy replaces the live mapping in a single cycle. The same resolve also releases that slot and every slot allocated after it. Wrong-path mappings are therefore discarded without draining the pipeline.

A separate drain-reset input points every architectural register back at the committed register file. The committed home of register `i` is physical tag `i`. Drain-reset also empties the slot pool. The commit side uses it once all older work has retired.

Top module: `rename_ckpt_rat`

## Requirements
- R1: After reset, entry `i` of `map_flat` holds tag `i` (identity mapping), all slots are free, and a branch request sees `br_stall` low with `br_id` = 0.
- R2: When `ren_valid` is high, and neither drain-reset nor a mispredict resolve is present, `map_flat` bits `[ren_arch*PTAG_W +: PTAG_W]` hold `ren_ptag` from the next cycle on. All other entries are unchanged.
- R3: While `br_valid` is high and a slot is free, `br_id` shows the lowest-numbered free slot in the same cycle. In a normal cycle that slot is captured. Its snapshot includes a rename presented in the same cycle.
- R4: `br_stall` is high in the same cycle exactly when `br_valid` is high and all slots are busy. A stalled branch captures nothing and takes no slot.
- R5: A resolve with `res_mispredict` low frees slot `res_id` and leaves the live mapping untouched.
- R6: A resolve with `res_mispredict` high makes `map_flat` equal, on the next cycle, the snapshot held by slot `res_id`. A rename or branch request in that same cycle is discarded.
- R7: A mispredict resolve frees slot `res_id` and every slot allocated after it. Slots allocated earlier stay busy.
- R8: `drain_reset` restores the identity mapping and frees all slots on the next cycle. It overrides any rename, branch or resolve in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request this cycle |
| ren_arch | input | $clog2(NUM_ARCH) | Architectural destination register |
| ren_ptag | input | PTAG_W | New physical tag for that register |
| br_valid | input | 1 | Branch wants a checkpoint |
| br_stall | output | 1 | No free slot; the branch must retry |
| br_id | output | $clog2(NUM_CKPT) | Slot granted to the branch |
| res_valid | input | 1 | Branch resolution present |
| res_id | input | $clog2(NUM_CKPT) | Slot of the resolving branch (must be busy) |
| res_mispredict | input | 1 | Resolution was a misprediction |
| drain_reset | input | 1 | Point all registers back at the committed file |
| map_flat | output | NUM_ARCH*PTAG_W | Live mapping, entry i at bits [i*PTAG_W +: PTAG_W] |

## Verification
`br_id` and `br_stall` are combinational from the slot pool. They are due in the same cycle a branch request is presented. The bench samples them 1 ns after driving the inputs, well before the capturing edge. Every mapping change (rename, restore, drain) passes through one register. It is therefore compared one edge later, at the following falling edge, against a bench model that applied the same request. Slot freeing has no output of its own. It becomes visible through the `br_id` and `br_stall` of later branch requests, which directed sequences issue right after each resolve.

// File: rtl/rat_pkg.sv
package rat_pkg;

    // Default geometry of the rename table
    parameter int DEF_NUM_ARCH = 16;
    parameter int DEF_PTAG_W   = 6;
    parameter int DEF_NUM_CKPT = 4;

    // Which kind of update the live table takes in a cycle
    typedef enum logic [1:0] {
        ACT_NORMAL  = 2'd0,
        ACT_RESTORE = 2'd1,
        ACT_DRAIN   = 2'd2
    } rat_act_e;

endpackage

// File: rtl/rat_slot_pick.sv
module rat_slot_pick #(
    parameter int SLOTS = 4,
    localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [SLOTS-1:0] busy,
    output logic             found,
    output logic [IW-1:0]    idx
);

    // Lowest-numbered free slot wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/rat_age_kill.sv
module rat_age_kill #(
    parameter int SLOTS = 4,
    localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [IW-1:0]    alloc_idx,
    input  logic [IW-1:0]    kill_idx,
    output logic [SLOTS-1:0] kill_mask
);

    // before_q[i][j] set: slot i was allocated before slot j
    logic [SLOTS-1:0][SLOTS-1:0] before_d, before_q;

    always_comb begin
        before_d = before_q;
        if (alloc_en) begin
            for (int i = 0; i < SLOTS; i++) begin
                before_d[i][alloc_idx] = 1'b1;   // everyone is older than the newcomer
                before_d[alloc_idx][i] = 1'b0;   // newcomer is older than nobody
            end
        end
        kill_mask           = before_q[kill_idx];
        kill_mask[kill_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) before_q <= '0;
        else        before_q <= before_d;
    end

endmodule

// File: rtl/rat_snap_store.sv
module rat_snap_store #(
    parameter int SLOTS = 4,
    parameter int DW    = 96,
    localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);

    logic [SLOTS-1:0][DW-1:0] snap_d, snap_q;
    logic [SLOTS-1:0]         slot_we;

    for (genvar s = 0; s < SLOTS; s++) begin : g_we
        assign slot_we[s] = wr_en && (wr_idx == IW'(s));
    end

    always_comb begin
        snap_d = snap_q;
        for (int s = 0; s < SLOTS; s++) begin
            if (slot_we[s]) snap_d[s] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    assign rd_data = snap_q[rd_idx];

endmodule

// File: rtl/rename_ckpt_rat.sv
module rename_ckpt_rat
    import rat_pkg::*;
#(
    parameter int NUM_ARCH = DEF_NUM_ARCH,
    parameter int PTAG_W   = DEF_PTAG_W,
    parameter int NUM_CKPT = DEF_NUM_CKPT,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int CW = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1,
    localparam int DW = NUM_ARCH * PTAG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    input  logic [AW-1:0] ren_arch,
    input  logic [PTAG_W-1:0] ren_ptag,
    input  logic          br_valid,
    output logic          br_stall,
    output logic [CW-1:0] br_id,
    input  logic          res_valid,
    input  logic [CW-1:0] res_id,
    input  logic          res_mispredict,
    input  logic          drain_reset,
    output logic [DW-1:0] map_flat
);

    typedef logic [NUM_ARCH-1:0][PTAG_W-1:0] map_t;

    typedef struct packed {
        map_t                map;
        logic [NUM_CKPT-1:0] busy;
    } rat_state_t;

    rat_state_t cur_q, cur_d;
    rat_act_e   act;
    map_t       ident_map, after_ren;
    logic       pick_found, grant;
    logic [CW-1:0]       pick_idx;
    logic [NUM_CKPT-1:0] kill_mask;
    logic [DW-1:0]       snap_rd;
    logic [NUM_CKPT-1:0] slot_busy_q;

    rat_slot_pick #(.SLOTS(NUM_CKPT)) u_pick (
        .busy  (cur_q.busy),
        .found (pick_found),
        .idx   (pick_idx)
    );

    rat_age_kill #(.SLOTS(NUM_CKPT)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (grant),
        .alloc_idx (pick_idx),
        .kill_idx  (res_id),
        .kill_mask (kill_mask)
    );

    rat_snap_store #(.SLOTS(NUM_CKPT), .DW(DW)) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (grant),
        .wr_idx  (pick_idx),
        .wr_data (after_ren),
        .rd_idx  (res_id),
        .rd_data (snap_rd)
    );

    // Home of every architectural register in the committed file
    for (genvar a = 0; a < NUM_ARCH; a++) begin : g_ident
        assign ident_map[a] = PTAG_W'(a);
    end

    always_comb begin
        if (drain_reset)                       act = ACT_DRAIN;
        else if (res_valid && res_mispredict)  act = ACT_RESTORE;
        else                                   act = ACT_NORMAL;

        // Live table as seen by a branch grouped after this cycle's rename
        after_ren = cur_q.map;
        if (ren_valid) after_ren[ren_arch] = ren_ptag;

        grant = br_valid && pick_found && (act == ACT_NORMAL);

        cur_d = cur_q;
        unique case (act)
            ACT_DRAIN: begin
                cur_d.map  = ident_map;
                cur_d.busy = '0;
            end
            ACT_RESTORE: begin
                cur_d.map  = snap_rd;
                cur_d.busy = cur_q.busy & ~kill_mask;
            end
            default: begin
                cur_d.map = after_ren;
                if (res_valid) cur_d.busy[res_id]   = 1'b0;
                if (grant)     cur_d.busy[pick_idx] = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.map  <= ident_map;
            cur_q.busy <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign br_stall    = br_valid && !pick_found;
    assign br_id       = pick_idx;
    assign map_flat    = cur_q.map;
    assign slot_busy_q = cur_q.busy;

endmodule

// File: rtl/rat_chk.sv
module rat_chk #(
    parameter int NUM_ARCH = 16,
    parameter int PTAG_W   = 6,
    parameter int NUM_CKPT = 4,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int CW = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1,
    localparam int DW = NUM_ARCH * PTAG_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ren_valid,
    input logic [AW-1:0] ren_arch,
    input logic [PTAG_W-1:0] ren_ptag,
    input logic          br_valid,
    input logic          br_stall,
    input logic [CW-1:0] br_id,
    input logic          res_valid,
    input logic          res_mispredict,
    input logic          drain_reset,
    input logic [DW-1:0] map_flat,
    input logic [NUM_CKPT-1:0] slot_busy
);

    logic [DW-1:0] home;
    always_comb begin
        for (int a = 0; a < NUM_ARCH; a++) home[a*PTAG_W +: PTAG_W] = PTAG_W'(a);
    end

    logic quiet;
    assign quiet = !drain_reset && !(res_valid && res_mispredict);

    // R4
    stall_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_stall |-> (&slot_busy));

    // R3
    grant_free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !br_stall) |-> !slot_busy[br_id]);

    // R3
    grant_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !br_stall && quiet) |=> slot_busy[$past(br_id)]);

    // R2
    rename_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && quiet) |=> map_flat[$past(ren_arch)*PTAG_W +: PTAG_W] == $past(ren_ptag));

    // R5
    good_resolve_keeps_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_mispredict && !ren_valid && !drain_reset) |=> $stable(map_flat));

    // R8
    drain_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drain_reset |=> (map_flat == home) && (slot_busy == '0));

endmodule

bind rename_ckpt_rat rat_chk #(
    .NUM_ARCH (NUM_ARCH),
    .PTAG_W   (PTAG_W),
    .NUM_CKPT (NUM_CKPT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ren_valid      (ren_valid),
    .ren_arch       (ren_arch),
    .ren_ptag       (ren_ptag),
    .br_valid       (br_valid),
    .br_stall       (br_stall),
    .br_id          (br_id),
    .res_valid      (res_valid),
    .res_mispredict (res_mispredict),
    .drain_reset    (drain_reset),
    .map_flat       (map_flat),
    .slot_busy      (slot_busy_q)
);

// File: tb/sim_rename_ckpt_rat.sv
module sim_rename_ckpt_rat;

    localparam int NA = 16;
    localparam int PW = 6;
    localparam int NC = 4;
    localparam int AW = 4;
    localparam int CW = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic          rst_n;
    logic          ren_valid;
    logic [AW-1:0] ren_arch;
    logic [PW-1:0] ren_ptag;
    logic          br_valid;
    logic          br_stall;
    logic [CW-1:0] br_id;
    logic          res_valid;
    logic [CW-1:0] res_id;
    logic          res_mispredict;
    logic          drain_reset;
    logic [NA*PW-1:0] map_flat;

    rename_ckpt_rat #(.NUM_ARCH(NA), .PTAG_W(PW), .NUM_CKPT(NC)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_arch(ren_arch), .ren_ptag(ren_ptag),
        .br_valid(br_valid), .br_stall(br_stall), .br_id(br_id),
        .res_valid(res_valid), .res_id(res_id), .res_mispredict(res_mispredict),
        .drain_reset(drain_reset), .map_flat(map_flat)
    );

    int errors = 0;
    int checks = 0;

    // Reference model
    int m_map [NA];
    int m_snap[NC][NA];
    bit m_busy[NC];
    int m_seq [NC];
    int seq_ctr = 0;

    function automatic logic [NA*PW-1:0] model_flat();
        logic [NA*PW-1:0] v;
        for (int i = 0; i < NA; i++) v[i*PW +: PW] = PW'(m_map[i]);
        return v;
    endfunction

    function automatic int lowest_free();
        for (int s = 0; s < NC; s++) if (!m_busy[s]) return s;
        return -1;
    endfunction

    task automatic model_home();
        for (int i = 0; i < NA; i++) m_map[i] = i;
        for (int s = 0; s < NC; s++) m_busy[s] = 1'b0;
    endtask

    task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock of stimulus; tag overrides the requirement named in checks
    task automatic step(bit ren, int a, int p, bit br, bit res, int id, bit misp, bit drn, string tag);
        int  f;
        bit  grant;
        string t_map, t_br, t_st;
        ren_valid      = ren;
        ren_arch       = AW'(a);
        ren_ptag       = PW'(p);
        br_valid       = br;
        res_valid      = res;
        res_id         = CW'(id);
        res_mispredict = misp;
        drain_reset    = drn;
        #1;
        f = lowest_free();
        t_br = (tag != "") ? tag : "R3";
        t_st = (tag != "") ? tag : "R4";
        if (br) begin
            chk(br_stall == (f < 0), t_st, "br_stall", 128'(br_stall), 128'(f < 0));
            if (f >= 0) chk(br_id == CW'(f), t_br, "br_id", 128'(br_id), 128'(f));
        end
        // Model next state
        grant = br && (f >= 0) && !drn && !(res && misp);
        if (drn) begin
            model_home();
        end else if (res && misp) begin
            for (int i = 0; i < NA; i++) m_map[i] = m_snap[id][i];
            for (int s = 0; s < NC; s++)
                if (m_busy[s] && m_seq[s] > m_seq[id]) m_busy[s] = 1'b0;
            m_busy[id] = 1'b0;
        end else begin
            if (ren) m_map[a] = p;
            if (res) m_busy[id] = 1'b0;
            if (grant) begin
                for (int i = 0; i < NA; i++) m_snap[f][i] = m_map[i];
                m_busy[f] = 1'b1;
                m_seq[f]  = seq_ctr;
                seq_ctr++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        ren_valid = 1'b0; br_valid = 1'b0; res_valid = 1'b0;
        res_mispredict = 1'b0; drain_reset = 1'b0;
        t_map = (tag != "") ? tag : (drn ? "R8" : ((res && misp) ? "R6" : "R2"));
        chk(map_flat == model_flat(), t_map, "map_flat", 128'(map_flat), 128'(model_flat()));
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int busy_list[NC];
        int nb;
        bit r_ren, r_br, r_res, r_misp, r_drn;
        int r_id;
        void'($urandom(32'd2718));
        rst_n = 1'b0;
        ren_valid = 1'b0; ren_arch = '0; ren_ptag = '0;
        br_valid = 1'b0; res_valid = 1'b0; res_id = '0;
        res_mispredict = 1'b0; drain_reset = 1'b0;
        model_home();
        for (int s = 0; s < NC; s++) m_seq[s] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(map_flat == model_flat(), "R1", "map_flat", 128'(map_flat), 128'(model_flat()));
        br_valid = 1'b1;
        #1;
        chk(br_stall == 1'b0, "R1", "br_stall", 128'(br_stall), 128'(0));
        chk(br_id == '0, "R1", "br_id", 128'(br_id), 128'(0));
        br_valid = 1'b0;
        @(negedge clk);

        // R3/R4/R5: fill all slots, stall, free one slot correctly
        for (int k = 0; k < NC; k++) step(1, k, 40 + k, 1, 0, 0, 0, 0, "R3");
        step(1, 5, 50, 1, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 1, 2, 0, 0, "R5");
        step(0, 0, 0, 1, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 1, 0, 0, 0, 0, "R4");

        // R6/R7: restore slot 1, drop same-cycle rename and branch, free younger slots
        step(0, 0, 0, 0, 0, 0, 0, 1, "R8");
        for (int k = 0; k < NC; k++) step(1, 2 * k, 20 + k, 1, 0, 0, 0, 0, "R3");
        step(1, 9, 63, 1, 1, 1, 1, 0, "R6");
        step(0, 0, 0, 1, 0, 0, 0, 0, "R7");
        step(0, 0, 0, 1, 0, 0, 0, 0, "R7");
        step(0, 0, 0, 1, 0, 0, 0, 0, "R7");
        step(0, 0, 0, 1, 0, 0, 0, 0, "R7");

        // R8: drain overrides everything in the same cycle
        step(1, 3, 33, 1, 1, 0, 1, 1, "R8");
        step(0, 0, 0, 1, 0, 0, 0, 0, "R8");

        // Random traffic
        for (int c = 0; c < 3000; c++) begin
            nb = 0;
            for (int s = 0; s < NC; s++) if (m_busy[s]) begin busy_list[nb] = s; nb++; end
            r_ren  = ($urandom % 10) < 7;
            r_br   = ($urandom % 10) < 3;
            r_res  = (nb > 0) && (($urandom % 4) == 0);
            r_id   = (nb > 0) ? busy_list[$urandom % nb] : 0;
            r_misp = r_res && (($urandom % 3) == 0);
            r_drn  = ($urandom % 60) == 0;
            step(r_ren, int'($urandom % NA), int'($urandom % 64), r_br,
                 r_res, r_id, r_misp, r_drn, "");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule